// File: doc/BRIEF.md
# Byte-Swapping Host Bus Bridge

This bridge sits between a 32-bit big-endian host bus and a little-endian communication subsystem. The host issues single-cycle strobes carrying an offset, a write flag, a four-lane byte-enable mask and write data. The bridge decodes the offset into one of three windows and forwards a one-cycle request to that window's target. The first window is a shared byte-wide communication RAM. The second is a bank of 16-bit controller registers. The third is the local processor's 16-bit work RAM.

Each window translates byte lanes in its own way. A byte access to the communication RAM keeps the host lane given by the offset, and the internal byte address has its two low bits inverted. The two halfword windows take data from the upper host halfword. They exchange the two bytes of that data, and of its byte-enable pair, on the way in. Read data has its bytes exchanged the same way on the way back. The targets use synchronous reads, so the bridge returns read data exactly one cycle after the strobe.

Top module: `swb_bridge`

## Requirements
- R1: Offsets 0x00000–0x0FFFF select the communication RAM, 0x10000–0x101FF the register bank, and 0x20000–0x3FFFF the local RAM. A strobe raises exactly one target request, in the same cycle and for that cycle only. No request is raised without a strobe.
- R2: The communication RAM byte address is the low 16 offset bits XOR 3.
- R3: A communication RAM write takes its byte from the host lane chosen by offset bits [1:0] (0 → bits 31:24, 1 → 23:16, 2 → 15:8, 3 → 7:0). A read returns the byte in that same lane, with all other lanes zero.
- R4: On a write to either halfword window, the target write data is host bits [31:16] with the two bytes exchanged (target [7:0] = host [31:24]).
- R5: On a read from either halfword window, host bits [31:16] are the target data with its bytes exchanged, and host bits [15:0] are zero.
- R6: The halfword byte enables are exchanged: target enable bit 0 = host enable bit 3, and target bit 1 = host bit 2.
- R7: The register index is offset bits [8:1]. The local RAM halfword address is offset bits [16:1].
- R8: An offset outside all three windows raises no request, and a read there returns zero.
- R9: The read valid flag is high exactly in the cycle after a read strobe. Writes never raise it. Read data is zero whenever the flag is low.
- R10: After reset the read valid flag is low and the read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 20 | Host byte offset |
| host_be | input | 4 | Host byte enables, bit 3 = bits 31:24 |
| host_wdata | input | 32 | Host write data, big-endian lanes |
| host_rdata | output | 32 | Read data returned to host |
| host_rvalid | output | 1 | Read data valid, one cycle after a read strobe |
| cr_req | output | 1 | Communication RAM request |
| cr_we | output | 1 | Communication RAM write |
| cr_addr | output | 16 | Communication RAM byte address |
| cr_wdata | output | 8 | Communication RAM write byte |
| cr_rdata | input | 8 | Communication RAM read byte (registered by target) |
| io_req | output | 1 | Register bank request |
| io_we | output | 1 | Register bank write |
| io_idx | output | 8 | Register index |
| io_be | output | 2 | Register byte enables, little-endian |
| io_wdata | output | 16 | Register write data |
| io_rdata | input | 16 | Register read data (registered by target) |
| lr_req | output | 1 | Local RAM request |
| lr_we | output | 1 | Local RAM write |
| lr_addr | output | 16 | Local RAM halfword address |
| lr_be | output | 2 | Local RAM byte enables, little-endian |
| lr_wdata | output | 16 | Local RAM write data |
| lr_rdata | input | 16 | Local RAM read data (registered by target) |

## Verification
The request, address, write data and enables on the target ports are combinational. They are due in the same cycle as the host strobe, so the bench checks them shortly after it drives the strobe on the falling edge, before the next rising edge. Read data passes through one register, the target's own read register, and is due in the next cycle. The bench checks it, together with the valid flag, at the following falling edge. It expects a value computed from the address-derived contents of its target stubs. A separate check on an idle cycle confirms that the valid flag and the data return to zero.

// File: rtl/swb_pkg.sv
package swb_pkg;

   typedef enum logic [1:0] {
      WIN_NONE  = 2'd0,
      WIN_COMM  = 2'd1,
      WIN_IOREG = 2'd2,
      WIN_LRAM  = 2'd3
   } swb_win_e;

   function automatic logic [15:0] swap_bytes16(input logic [15:0] v);
      return {v[7:0], v[15:8]};
   endfunction

   function automatic logic [1:0] swap_pair(input logic [1:0] v);
      return {v[0], v[1]};
   endfunction

endpackage

// File: rtl/swb_window_decode.sv
module swb_window_decode
   import swb_pkg::*;
#(
   parameter int HOST_AW      = 20,
   parameter int COMM_BASE    = 32'h00000,
   parameter int COMM_LOG2    = 16,
   parameter int IO_BASE      = 32'h10000,
   parameter int IO_LOG2      = 9,
   parameter int LR_BASE      = 32'h20000,
   parameter int LR_LOG2      = 17
) (
   input  logic [HOST_AW-1:0] addr,
   output swb_win_e           win
);

   localparam logic [HOST_AW-1:0] COMM_TAG = HOST_AW'(COMM_BASE >> COMM_LOG2);
   localparam logic [HOST_AW-1:0] IO_TAG   = HOST_AW'(IO_BASE >> IO_LOG2);
   localparam logic [HOST_AW-1:0] LR_TAG   = HOST_AW'(LR_BASE >> LR_LOG2);

   if ((COMM_BASE % (1 << COMM_LOG2)) != 0) begin : g_bad_comm
      $error("communication window base not aligned to its span");
   end
   if ((IO_BASE % (1 << IO_LOG2)) != 0) begin : g_bad_io
      $error("register window base not aligned to its span");
   end
   if ((LR_BASE % (1 << LR_LOG2)) != 0) begin : g_bad_lr
      $error("local RAM window base not aligned to its span");
   end
   if (LR_BASE + (1 << LR_LOG2) > (1 << HOST_AW)) begin : g_bad_aw
      $error("host offset too narrow for local RAM window");
   end

   logic hit_comm, hit_io, hit_lr;

   always_comb begin
      hit_comm = (addr >> COMM_LOG2) == COMM_TAG;
      hit_io   = (addr >> IO_LOG2)   == IO_TAG;
      hit_lr   = (addr >> LR_LOG2)   == LR_TAG;
      if (hit_comm)      win = WIN_COMM;
      else if (hit_io)   win = WIN_IOREG;
      else if (hit_lr)   win = WIN_LRAM;
      else               win = WIN_NONE;
   end

endmodule

// File: rtl/swb_byte_lane.sv
module swb_byte_lane #(
   parameter int HOST_DW = 32,
   parameter int CR_AW   = 16,
   localparam int NLANE  = HOST_DW / 8,
   localparam int LANE_W = $clog2(NLANE)
) (
   input  logic [CR_AW-1:0]   off,
   input  logic [LANE_W-1:0]  lane_q,
   input  logic [HOST_DW-1:0] wdata,
   input  logic [7:0]         rd_byte,
   output logic [CR_AW-1:0]   cr_addr,
   output logic [7:0]         cr_wdata,
   output logic [HOST_DW-1:0] rd_word
);

   localparam logic [CR_AW-1:0] FLIP = CR_AW'(NLANE - 1);

   if (NLANE < 2 || (NLANE & (NLANE - 1)) != 0) begin : g_bad_dw
      $error("host data width must be a power-of-two number of bytes");
   end

   logic [7:0] lane_byte [NLANE];

   for (genvar l = 0; l < NLANE; l++) begin : g_lane
      assign lane_byte[l] = wdata[HOST_DW-1-8*l -: 8];
      assign rd_word[HOST_DW-1-8*l -: 8] =
         (lane_q == LANE_W'(l)) ? rd_byte : 8'h00;
   end

   assign cr_addr  = off ^ FLIP;
   assign cr_wdata = lane_byte[off[LANE_W-1:0]];

endmodule

// File: rtl/swb_half_lane.sv
module swb_half_lane
   import swb_pkg::*;
#(
   parameter int HOST_DW = 32,
   parameter bit UPPER   = 1'b1,
   localparam int NBE    = HOST_DW / 8
) (
   input  logic [HOST_DW-1:0] wdata,
   input  logic [NBE-1:0]     be,
   input  logic [15:0]        rd_half,
   output logic [15:0]        t_wdata,
   output logic [1:0]         t_be,
   output logic [HOST_DW-1:0] rd_word
);

   logic [15:0] host_half;
   logic [1:0]  host_be2;

   if (UPPER) begin : g_upper
      assign host_half = wdata[HOST_DW-1 -: 16];
      assign host_be2  = be[NBE-1 -: 2];
      assign rd_word   = {swap_bytes16(rd_half), {(HOST_DW-16){1'b0}}};
      logic unused_lo;
      assign unused_lo = ^{wdata[HOST_DW-17:0], be[NBE-3:0]};
   end else begin : g_lower
      assign host_half = wdata[15:0];
      assign host_be2  = be[1:0];
      assign rd_word   = {{(HOST_DW-16){1'b0}}, swap_bytes16(rd_half)};
      logic unused_hi;
      assign unused_hi = ^{wdata[HOST_DW-1:16], be[NBE-1:2]};
   end

   assign t_wdata = swap_bytes16(host_half);
   assign t_be    = swap_pair(host_be2);

endmodule

// File: rtl/swb_bridge.sv
module swb_bridge
   import swb_pkg::*;
#(
   parameter int HOST_AW   = 20,
   parameter int HOST_DW   = 32,
   parameter int COMM_BASE = 32'h00000,
   parameter int COMM_LOG2 = 16,
   parameter int IO_BASE   = 32'h10000,
   parameter int IO_LOG2   = 9,
   parameter int LR_BASE   = 32'h20000,
   parameter int LR_LOG2   = 17,
   localparam int NBE      = HOST_DW / 8,
   localparam int LANE_W   = $clog2(NBE),
   localparam int CR_AW    = COMM_LOG2,
   localparam int IO_IW    = IO_LOG2 - 1,
   localparam int LR_AW    = LR_LOG2 - 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_req,
   input  logic               host_we,
   input  logic [HOST_AW-1:0] host_addr,
   input  logic [NBE-1:0]     host_be,
   input  logic [HOST_DW-1:0] host_wdata,
   output logic [HOST_DW-1:0] host_rdata,
   output logic               host_rvalid,
   output logic               cr_req,
   output logic               cr_we,
   output logic [CR_AW-1:0]   cr_addr,
   output logic [7:0]         cr_wdata,
   input  logic [7:0]         cr_rdata,
   output logic               io_req,
   output logic               io_we,
   output logic [IO_IW-1:0]   io_idx,
   output logic [1:0]         io_be,
   output logic [15:0]        io_wdata,
   input  logic [15:0]        io_rdata,
   output logic               lr_req,
   output logic               lr_we,
   output logic [LR_AW-1:0]   lr_addr,
   output logic [1:0]         lr_be,
   output logic [15:0]        lr_wdata,
   input  logic [15:0]        lr_rdata
);

   if (IO_LOG2 < 2 || LR_LOG2 < 2 || COMM_LOG2 < LANE_W) begin : g_bad_span
      $error("window spans too small for the chosen access widths");
   end

   swb_win_e              win, win_q;
   logic                  rvalid_q;
   logic [LANE_W-1:0]     lane_q;
   logic [HOST_DW-1:0]    comm_rd, io_rd, lr_rd;

   swb_window_decode #(
      .HOST_AW(HOST_AW), .COMM_BASE(COMM_BASE), .COMM_LOG2(COMM_LOG2),
      .IO_BASE(IO_BASE), .IO_LOG2(IO_LOG2),
      .LR_BASE(LR_BASE), .LR_LOG2(LR_LOG2)
   ) u_dec (
      .addr (host_addr),
      .win  (win)
   );

   swb_byte_lane #(.HOST_DW(HOST_DW), .CR_AW(CR_AW)) u_comm (
      .off      (host_addr[CR_AW-1:0]),
      .lane_q   (lane_q),
      .wdata    (host_wdata),
      .rd_byte  (cr_rdata),
      .cr_addr  (cr_addr),
      .cr_wdata (cr_wdata),
      .rd_word  (comm_rd)
   );

   swb_half_lane #(.HOST_DW(HOST_DW), .UPPER(1'b1)) u_io (
      .wdata   (host_wdata),
      .be      (host_be),
      .rd_half (io_rdata),
      .t_wdata (io_wdata),
      .t_be    (io_be),
      .rd_word (io_rd)
   );

   swb_half_lane #(.HOST_DW(HOST_DW), .UPPER(1'b1)) u_lr (
      .wdata   (host_wdata),
      .be      (host_be),
      .rd_half (lr_rdata),
      .t_wdata (lr_wdata),
      .t_be    (lr_be),
      .rd_word (lr_rd)
   );

   assign cr_req  = host_req && (win == WIN_COMM);
   assign io_req  = host_req && (win == WIN_IOREG);
   assign lr_req  = host_req && (win == WIN_LRAM);
   assign cr_we   = host_we;
   assign io_we   = host_we;
   assign lr_we   = host_we;
   assign io_idx  = host_addr[IO_IW:1];
   assign lr_addr = host_addr[LR_AW:1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rvalid_q <= 1'b0;
         win_q    <= WIN_NONE;
         lane_q   <= '0;
      end else begin
         rvalid_q <= host_req && !host_we;
         if (host_req && !host_we) begin
            win_q  <= win;
            lane_q <= host_addr[LANE_W-1:0];
         end
      end
   end

   always_comb begin
      host_rdata = '0;
      if (rvalid_q) begin
         unique case (win_q)
            WIN_COMM:  host_rdata = comm_rd;
            WIN_IOREG: host_rdata = io_rd;
            WIN_LRAM:  host_rdata = lr_rd;
            default:   host_rdata = '0;
         endcase
      end
   end

   assign host_rvalid = rvalid_q;

endmodule

// File: rtl/swb_bridge_chk.sv
module swb_bridge_chk #(
   parameter int HOST_AW = 20,
   parameter int HOST_DW = 32,
   parameter int CR_AW   = 16,
   parameter int IO_BASE = 32'h10000,
   parameter int IO_LOG2 = 9,
   localparam int NBE    = HOST_DW / 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               host_req,
   input logic               host_we,
   input logic [HOST_AW-1:0] host_addr,
   input logic [NBE-1:0]     host_be,
   input logic [HOST_DW-1:0] host_rdata,
   input logic               host_rvalid,
   input logic               cr_req,
   input logic [CR_AW-1:0]   cr_addr,
   input logic               io_req,
   input logic [1:0]         io_be,
   input logic               lr_req
);

   localparam logic [HOST_AW-1:0] IO_TAG = HOST_AW'(IO_BASE >> IO_LOG2);

   logic any_req;
   assign any_req = cr_req || io_req || lr_req;

   p_one_target_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cr_req, io_req, lr_req}));

   p_req_needs_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
      any_req |-> host_req);

   p_comm_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cr_req |-> (cr_addr[1:0] == ~host_addr[1:0]) && (cr_addr[CR_AW-1:2] == host_addr[CR_AW-1:2]));

   p_be_swap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      io_req |-> (io_be[0] == host_be[NBE-1]) && (io_be[1] == host_be[NBE-2]));

   p_io_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (host_req && ((host_addr >> IO_LOG2) == IO_TAG)) |-> io_req);

   p_read_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (host_req && !host_we) |=> host_rvalid);

   p_no_spurious_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_req && !host_we) |=> !host_rvalid);

   p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !host_rvalid |-> (host_rdata == '0));

   p_outside_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (host_req && !host_we && !any_req) |=> (host_rdata == '0));

   p_half_low_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (io_req && !host_we) |=> (host_rdata[15:0] == 16'h0000));

endmodule

bind swb_bridge swb_bridge_chk #(
   .HOST_AW(HOST_AW), .HOST_DW(HOST_DW), .CR_AW(CR_AW),
   .IO_BASE(IO_BASE), .IO_LOG2(IO_LOG2)
) u_chk (
   .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
   .host_addr(host_addr), .host_be(host_be), .host_rdata(host_rdata),
   .host_rvalid(host_rvalid), .cr_req(cr_req), .cr_addr(cr_addr),
   .io_req(io_req), .io_be(io_be), .lr_req(lr_req)
);

// File: tb/sim_swb_bridge.sv
module sim_swb_bridge;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_req = 1'b0, host_we = 1'b0;
   logic [19:0] host_addr = '0;
   logic [3:0]  host_be = '0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        host_rvalid;
   logic        cr_req, cr_we, io_req, io_we, lr_req, lr_we;
   logic [15:0] cr_addr, lr_addr, io_wdata, lr_wdata;
   logic [7:0]  cr_wdata, io_idx;
   logic [1:0]  io_be, lr_be;
   logic [7:0]  cr_rdata = 8'h00;
   logic [15:0] io_rdata = 16'h0, lr_rdata = 16'h0;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   swb_bridge u0 (
      .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
      .host_addr(host_addr), .host_be(host_be), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .host_rvalid(host_rvalid),
      .cr_req(cr_req), .cr_we(cr_we), .cr_addr(cr_addr), .cr_wdata(cr_wdata),
      .cr_rdata(cr_rdata),
      .io_req(io_req), .io_we(io_we), .io_idx(io_idx), .io_be(io_be),
      .io_wdata(io_wdata), .io_rdata(io_rdata),
      .lr_req(lr_req), .lr_we(lr_we), .lr_addr(lr_addr), .lr_be(lr_be),
      .lr_wdata(lr_wdata), .lr_rdata(lr_rdata)
   );

   function automatic logic [7:0] f_cr(input logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h5A;
   endfunction
   function automatic logic [15:0] f_io(input logic [7:0] i);
      return {~i, i ^ 8'h3C};
   endfunction
   function automatic logic [15:0] f_lr(input logic [15:0] a);
      return {a[7:0] ^ 8'hC3, a[15:8]};
   endfunction

   always @(posedge clk) begin
      cr_rdata <= (cr_req && !cr_we) ? f_cr(cr_addr) : 8'hEE;
      io_rdata <= (io_req && !io_we) ? f_io(io_idx) : 16'hDEAD;
      lr_rdata <= (lr_req && !lr_we) ? f_lr(lr_addr) : 16'hBEEF;
   end

   // 0 none, 1 comm RAM, 2 registers, 3 local RAM
   function automatic int exp_win(input logic [19:0] a);
      if (a < 20'h10000) return 1;
      if (a >= 20'h10000 && a < 20'h10200) return 2;
      if (a >= 20'h20000 && a < 20'h40000) return 3;
      return 0;
   endfunction

   function automatic logic [31:0] exp_rd(input logic [19:0] a);
      logic [15:0] h;
      case (exp_win(a))
         1: return {24'h0, f_cr(a[15:0] ^ 16'h3)} << (8 * (3 - a[1:0]));
         2: begin h = f_io(a[8:1]);  return {h[7:0], h[15:8], 16'h0}; end
         3: begin h = f_lr(a[16:1]); return {h[7:0], h[15:8], 16'h0}; end
         default: return 32'h0;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic access(input bit we, input logic [19:0] a,
                         input logic [31:0] d, input logic [3:0] be);
      int w;
      w = exp_win(a);
      @(negedge clk);
      host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d; host_be = be;
      #1;
      chk("R1 request select", {29'h0, lr_req, io_req, cr_req},
          (w == 0) ? 32'h0 : (32'h1 << (w - 1)));
      if (w == 0) chk("R8 outside no request", {29'h0, lr_req, io_req, cr_req}, 32'h0);
      if (w == 1) begin
         chk("R2 comm address", {16'h0, cr_addr}, {16'h0, a[15:0] ^ 16'h3});
         chk("R3 comm write lane", {24'h0, cr_wdata}, {24'h0, d[31 - 8*a[1:0] -: 8]});
         chk("R1 comm we", {31'h0, cr_we}, {31'h0, we});
      end
      if (w == 2) begin
         chk("R7 register index", {24'h0, io_idx}, {24'h0, a[8:1]});
         chk("R4 register wdata", {16'h0, io_wdata}, {16'h0, d[23:16], d[31:24]});
         chk("R6 register be", {30'h0, io_be}, {30'h0, be[2], be[3]});
         chk("R1 register we", {31'h0, io_we}, {31'h0, we});
      end
      if (w == 3) begin
         chk("R7 local address", {16'h0, lr_addr}, {16'h0, a[16:1]});
         chk("R4 local wdata", {16'h0, lr_wdata}, {16'h0, d[23:16], d[31:24]});
         chk("R6 local be", {30'h0, lr_be}, {30'h0, be[2], be[3]});
      end
      @(negedge clk);
      host_req = 1'b0;
      #1;
      chk("R1 request one cycle", {29'h0, lr_req, io_req, cr_req}, 32'h0);
      chk("R9 rvalid", {31'h0, host_rvalid}, {31'h0, !we});
      if (!we) begin
         if (w == 1)      chk("R3 comm read lane", host_rdata, exp_rd(a));
         else if (w == 0) chk("R8 outside reads zero", host_rdata, 32'h0);
         else             chk("R5 halfword read swap", host_rdata, exp_rd(a));
      end else begin
         chk("R9 write rdata zero", host_rdata, 32'h0);
      end
   endtask

   function automatic logic [19:0] rand_addr();
      int k;
      k = $urandom % 5;
      case (k)
         0: return {4'h0, 16'($urandom)};
         1: return 20'h10000 | 20'($urandom % 512);
         2: return 20'h20000 | 20'($urandom % 131072);
         3: return 20'h10200 + 20'($urandom % 20'hFE00);
         default: return 20'($urandom);
      endcase
   endfunction

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      chk("R10 reset rvalid", {31'h0, host_rvalid}, 32'h0);
      chk("R10 reset rdata", host_rdata, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      // directed corners: window edges and every comm lane
      for (int i = 0; i < 4; i++) access(1'b0, 20'h00100 + 20'(i), 32'h0, 4'h0);
      for (int i = 0; i < 4; i++) access(1'b1, 20'h0ABC0 + 20'(i), 32'hA1B2C3D4, 4'hF);
      access(1'b0, 20'h0FFFF, 32'h0, 4'h0);
      access(1'b0, 20'h10000, 32'h0, 4'hC);
      access(1'b0, 20'h101FE, 32'h0, 4'hC);
      access(1'b0, 20'h10200, 32'h0, 4'hC);
      access(1'b1, 20'h10200, 32'h12345678, 4'hC);
      access(1'b0, 20'h1FFFE, 32'h0, 4'hC);
      access(1'b0, 20'h20000, 32'h0, 4'hC);
      access(1'b0, 20'h3FFFE, 32'h0, 4'hC);
      access(1'b0, 20'h40000, 32'h0, 4'hC);
      access(1'b1, 20'h10042, 32'hCAFE0000, 4'h8);
      access(1'b1, 20'h10042, 32'hCAFE0000, 4'h4);
      access(1'b1, 20'h2AAAA, 32'h55AA1234, 4'hC);
      access(1'b0, 20'hFFFFF, 32'h0, 4'h0);
      // idle: valid and data back to zero
      @(negedge clk); #1;
      chk("R9 idle rvalid", {31'h0, host_rvalid}, 32'h0);
      chk("R9 idle rdata", host_rdata, 32'h0);
      for (int i = 0; i < 400; i++)
         access(1'($urandom), rand_addr(), $urandom, 4'($urandom));
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog expired act=%0d exp=%0d", n_chk, 0);
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule